// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps a 512-row dynamic RAM alive. After reset it waits a programmable power-up pause. It then queues a fixed burst of warm-up refresh cycles and runs them. Once the last warm-up cycle has finished its precharge, it raises `init_done_o`. From then on a free-running interval timer queues one refresh per interval, so that every row is visited within the retention period. The default is 1560 cycles at 100 MHz, which puts 512 refreshes inside 8 ms.

The sequencer owns the RAS and CAS strobes only while it holds a grant from the memory access controller. It raises `req_o` and waits for `grant_i`. It then drives one refresh cycle, or several back to back if refreshes have queued up. It drops `req_o` after the last precharge, and the controller takes the bus back on the next cycle. Each cycle is either CAS-before-RAS, which relies on the RAM's internal row counter, or RAS-only. In RAS-only mode CAS stays high and a 9-bit row counter drives `row_addr_o`. An interval that expires while a refresh is still waiting for the grant sets a sticky overflow flag. Missed refreshes are never dropped.

Top module: `dram_refresh_sched`

## Requirements
- R1: While `rst_ni` is low: `req_o`=0, `ras_n_o`=1, `cas_n_o`=1, `init_done_o`=0, `overflow_o`=0 and `row_addr_o`=0.
- R2: `req_o` stays low for the first PAUSE_CYC clock cycles after reset is released, and rises within two cycles after that.
- R3: After the pause, exactly WARMUP_CNT refresh cycles run before any interval refresh. `init_done_o` rises once the last of them has finished precharge, and stays high until reset.
- R4: In a CAS-before-RAS cycle, `cas_n_o` is low for exactly CSR_CYC cycles before `ras_n_o` falls. It then stays low for exactly CHR_CYC cycles of the RAS-low time and returns high.
- R5: Every refresh holds `ras_n_o` low for exactly RAS_LOW_CYC cycles. Between two refreshes `ras_n_o` is high for at least PRECH_CYC cycles.
- R6: After warm-up, one refresh is queued every INTERVAL_CYC cycles. With a constant grant latency, successive RAS falls are exactly INTERVAL_CYC cycles apart.
- R7: `req_o` stays high until `grant_i` arrives. `ras_n_o` and `cas_n_o` go low only while `grant_i` is high. `req_o` falls after the precharge of the last queued refresh.
- R8: If an interval expires while a queued refresh is still waiting for the grant, `overflow_o` is set and stays set until reset. Otherwise it stays low.
- R9: Queued refreshes run back to back under one grant. A CAS-before-RAS cycle starts every CSR_CYC+RAS_LOW_CYC+PRECH_CYC cycles, and exactly the number of missed refreshes is issued.
- R10: A RAS-only cycle keeps `cas_n_o` high throughout. At the RAS fall, `row_addr_o` shows the row for that cycle. The row then advances by one, wrapping from 511 to 0.
- R11: `ras_only_i` is sampled when a cycle starts: 0 gives CAS-before-RAS and 1 gives RAS-only. Changing it while no request is pending has no effect on any cycle already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_only_i | input | 1 | 1 selects RAS-only refresh with the row counter; 0 selects CAS-before-RAS |
| grant_i | input | 1 | Bus grant from the access controller |
| req_o | output | 1 | Bus request for refresh |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| row_addr_o | output | ROW_W | Row address for RAS-only cycles |
| init_done_o | output | 1 | Power-up sequence complete |
| overflow_o | output | 1 | Sticky: an interval expired while a refresh was still waiting for the grant |

## Verification
The bench watches the strobes cycle by cycle and measures every CAS setup, CAS hold, RAS-low run and precharge gap. A sequencer that is off by one in any of its counters therefore shows up as a wrong width. A directed window withholds the grant for exactly three intervals. A design that lost missed refreshes would issue fewer than three back-to-back cycles after that window. One that double-counted would issue a fourth. One that failed to flag the miss would leave `overflow_o` low. A long RAS-only run with random grant latency and mode switching crosses the 511-to-0 wrap, which exposes a row counter that advances on the wrong event or skips a row.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_REQ,
    SQ_CSR,
    SQ_RAS,
    SQ_PRE
  } sq_state_e;

  typedef enum logic {
    RF_CBR = 1'b0,
    RF_ROW = 1'b1
  } rf_kind_e;

endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int unsigned PAUSE_CYC    = 20000,
  parameter int unsigned INTERVAL_CYC = 1560,
  parameter int unsigned WARMUP_CNT   = 8,
  parameter int unsigned PEND_W       = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic done_i,
  output logic pend_nz_o,
  output logic init_done_o,
  output logic overflow_o
);

  localparam int unsigned TOP  = (PAUSE_CYC > INTERVAL_CYC) ? PAUSE_CYC : INTERVAL_CYC;
  localparam int unsigned TW   = $clog2(TOP + 1);
  localparam int unsigned SW   = PEND_W + 2;
  localparam int unsigned PMAX = (1 << PEND_W) - 1;
  localparam int unsigned WW   = $clog2(WARMUP_CNT + 1);
  localparam logic [TW-1:0] PAUSE_LD = TW'(PAUSE_CYC - 1);
  localparam logic [TW-1:0] IVAL_LD  = TW'(INTERVAL_CYC - 1);

  logic          run_q;
  logic [TW-1:0] tmr_q;
  logic [PEND_W-1:0] pend_q;
  logic [WW-1:0] warm_q;
  logic          init_q;
  logic          ovf_q;

  logic          expire, tick, pause_end;
  logic [SW-1:0] after_take, add, sum;

  assign expire    = (tmr_q == '0);
  assign tick      = run_q & expire;
  assign pause_end = ~run_q & expire;

  always_comb begin
    after_take = SW'(pend_q) - SW'(take_i);
    add        = '0;
    if (pause_end) add = SW'(WARMUP_CNT);
    else if (tick) add = SW'(1);
    sum = after_take + add;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      tmr_q  <= PAUSE_LD;
      pend_q <= '0;
    end else begin
      if (expire) begin
        run_q <= 1'b1;
        tmr_q <= IVAL_LD;
      end else begin
        tmr_q <= tmr_q - 1'b1;
      end
      // saturate the queue of owed refreshes
      if (sum > SW'(PMAX)) pend_q <= PEND_W'(PMAX);
      else                 pend_q <= sum[PEND_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warm_q <= '0;
      init_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (done_i && !init_q) begin
        warm_q <= warm_q + 1'b1;
        if (warm_q == WW'(WARMUP_CNT - 1)) init_q <= 1'b1;
      end
      if (tick && (after_take != '0)) ovf_q <= 1'b1;
    end
  end

  assign pend_nz_o   = (pend_q != '0);
  assign init_done_o = init_q;
  assign overflow_o  = ovf_q;

endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned CSR_CYC     = 1,
  parameter int unsigned CHR_CYC     = 2,
  parameter int unsigned RAS_LOW_CYC = 6,
  parameter int unsigned PRECH_CYC   = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     grant_i,
  input  logic     pend_nz_i,
  input  logic     ras_only_i,
  output logic     req_o,
  output logic     ras_n_o,
  output logic     cas_n_o,
  output logic     take_o,
  output logic     done_o,
  output rf_kind_e kind_o
);

  localparam int unsigned M1   = (CSR_CYC > RAS_LOW_CYC) ? CSR_CYC : RAS_LOW_CYC;
  localparam int unsigned CMAX = (M1 > PRECH_CYC) ? M1 : PRECH_CYC;
  localparam int unsigned CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] CSR_LD  = CW'(CSR_CYC - 1);
  localparam logic [CW-1:0] RAS_LD  = CW'(RAS_LOW_CYC - 1);
  localparam logic [CW-1:0] PRE_LD  = CW'(PRECH_CYC - 1);
  localparam logic [CW-1:0] CAS_REL = CW'(RAS_LOW_CYC - 1 - CHR_CYC);

  sq_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  rf_kind_e kind_q, kind_d;
  logic launch;

  always_comb begin
    state_d = state_q;
    cnt_d   = (cnt_q == '0) ? cnt_q : cnt_q - 1'b1;
    kind_d  = kind_q;
    launch  = 1'b0;
    done_o  = 1'b0;
    unique case (state_q)
      SQ_IDLE: if (pend_nz_i) state_d = SQ_REQ;
      SQ_REQ:  if (grant_i) launch = 1'b1;
      SQ_CSR:  if (cnt_q == '0) begin
                 state_d = SQ_RAS;
                 cnt_d   = RAS_LD;
               end
      SQ_RAS:  if (cnt_q == '0) begin
                 state_d = SQ_PRE;
                 cnt_d   = PRE_LD;
               end
      SQ_PRE:  if (cnt_q == '0) begin
                 done_o = 1'b1;
                 if (pend_nz_i && grant_i) launch = 1'b1;
                 else state_d = SQ_IDLE;
               end
      default: state_d = SQ_IDLE;
    endcase
    if (launch) begin
      if (ras_only_i) begin
        kind_d  = RF_ROW;
        state_d = SQ_RAS;
        cnt_d   = RAS_LD;
      end else begin
        kind_d  = RF_CBR;
        state_d = SQ_CSR;
        cnt_d   = CSR_LD;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      kind_q  <= RF_CBR;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      kind_q  <= kind_d;
    end
  end

  assign take_o  = launch;
  assign kind_o  = kind_q;
  assign req_o   = (state_q != SQ_IDLE);
  assign ras_n_o = (state_q != SQ_RAS);

  always_comb begin
    cas_n_o = 1'b1;
    if (state_q == SQ_CSR) cas_n_o = 1'b0;
    // CBR hold: CAS stays low for the first CHR_CYC cycles of RAS low
    else if (state_q == SQ_RAS && kind_q == RF_CBR && cnt_q > CAS_REL) cas_n_o = 1'b0;
  end

endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
  parameter int unsigned ROW_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [ROW_W-1:0] row_o
);

  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     row_q <= '0;
    else if (step_i) row_q <= row_q + 1'b1;
  end

  assign row_o = row_q;

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned ROW_W        = 9,
  parameter int unsigned PAUSE_CYC    = 20000,
  parameter int unsigned WARMUP_CNT   = 8,
  parameter int unsigned INTERVAL_CYC = 1560,
  parameter int unsigned CSR_CYC      = 1,
  parameter int unsigned CHR_CYC      = 2,
  parameter int unsigned RAS_LOW_CYC  = 6,
  parameter int unsigned PRECH_CYC    = 4,
  parameter int unsigned PEND_W       = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_only_i,
  input  logic             grant_i,
  output logic             req_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic [ROW_W-1:0] row_addr_o,
  output logic             init_done_o,
  output logic             overflow_o
);

  logic     pend_nz, take, done;
  rf_kind_e seq_kind;

  rfsh_timer #(
    .PAUSE_CYC   (PAUSE_CYC),
    .INTERVAL_CYC(INTERVAL_CYC),
    .WARMUP_CNT  (WARMUP_CNT),
    .PEND_W      (PEND_W)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take),
    .done_i     (done),
    .pend_nz_o  (pend_nz),
    .init_done_o(init_done_o),
    .overflow_o (overflow_o)
  );

  rfsh_seq #(
    .CSR_CYC    (CSR_CYC),
    .CHR_CYC    (CHR_CYC),
    .RAS_LOW_CYC(RAS_LOW_CYC),
    .PRECH_CYC  (PRECH_CYC)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .grant_i   (grant_i),
    .pend_nz_i (pend_nz),
    .ras_only_i(ras_only_i),
    .req_o     (req_o),
    .ras_n_o   (ras_n_o),
    .cas_n_o   (cas_n_o),
    .take_o    (take),
    .done_o    (done),
    .kind_o    (seq_kind)
  );

  rfsh_row_ctr #(
    .ROW_W(ROW_W)
  ) u_row (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(done && (seq_kind == RF_ROW)),
    .row_o (row_addr_o)
  );

endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int unsigned ROW_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             grant_i,
  input logic             req_o,
  input logic             ras_n_o,
  input logic             cas_n_o,
  input logic [ROW_W-1:0] row_addr_o,
  input logic             init_done_o,
  input logic             overflow_o,
  input logic             kind_i
);

  a_r7_strobe_needs_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o || !cas_n_o) |-> grant_i);

  a_r7_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !grant_i) |=> req_o);

  a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  a_r3_init_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

  a_r4_cas_before_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_o) && !cas_n_o) |-> $past(!cas_n_o));

  a_r10_row_cas_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o && kind_i) |-> cas_n_o);

  a_r10_row_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(row_addr_o) |-> (row_addr_o == $past(row_addr_o) + 1'b1));

  a_r10_row_stable_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o && $past(!ras_n_o)) |-> $stable(row_addr_o));

endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(.ROW_W(ROW_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .grant_i    (grant_i),
  .req_o      (req_o),
  .ras_n_o    (ras_n_o),
  .cas_n_o    (cas_n_o),
  .row_addr_o (row_addr_o),
  .init_done_o(init_done_o),
  .overflow_o (overflow_o),
  .kind_i     (seq_kind)
);

// File: tb/tb_dram_refresh_sched.sv
`timescale 1ns/1ps
module tb_dram_refresh_sched;

  localparam int ROW_W = 9;
  localparam int PAUSE = 300;
  localparam int WARM  = 8;
  localparam int IVAL  = 120;
  localparam int CSR   = 2;
  localparam int CHR   = 3;
  localparam int RASL  = 6;
  localparam int PRE   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_tb = 1'b0;
  logic grant = 1'b0;
  logic req, ras_n, cas_n, init_done, ovf;
  logic [ROW_W-1:0] row;

  always #5 clk = ~clk;

  dram_refresh_sched #(
    .ROW_W(ROW_W), .PAUSE_CYC(PAUSE), .WARMUP_CNT(WARM), .INTERVAL_CYC(IVAL),
    .CSR_CYC(CSR), .CHR_CYC(CHR), .RAS_LOW_CYC(RASL), .PRECH_CYC(PRE), .PEND_W(4)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .ras_only_i(mode_tb), .grant_i(grant),
    .req_o(req), .ras_n_o(ras_n), .cas_n_o(cas_n), .row_addr_o(row),
    .init_done_o(init_done), .overflow_o(ovf)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic int b2b_len(input bit ro);
    return (ro ? 0 : CSR) + RASL + PRE;
  endfunction

  function automatic int next_row(input int r);
    return (r + 1) % (1 << ROW_W);
  endfunction

  // monitor state
  int cyc = 0, first_req = 0;
  bit early_req = 0;
  bit prev_ras = 1, cur_ro = 0, ro_cas_bad = 0, prev_init = 0;
  int cas_pre = 0, cas_hold = 0, low_run = 0, high_run = 0;
  int n_falls = 0, n_rises = 0, n_ro = 0, last_fall = 0, last_spacing = 0;
  int exp_row = 0, ro_after_wrap = 0;
  bit wrapped = 0;
  // grant driver state
  int gdelay = 0, wt = 0;
  bit blocked = 0, rnd_delay = 0, rnd_mode = 0;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cyc++;
      if (req && first_req == 0) first_req = cyc;
      if (cyc < PAUSE && req) early_req = 1;
      if (!ras_n || !cas_n) check(grant, "R7 strobe without grant", grant, 1);
      if (prev_ras && !ras_n) begin
        cur_ro = cas_n;
        check(cur_ro == mode_tb, "R11 cycle kind", cur_ro, mode_tb);
        if (!cur_ro) check(cas_pre == CSR, "R4 cas setup", cas_pre, CSR);
        else begin
          check(int'(row) == exp_row, "R10 row at ras fall", row, exp_row);
          if (wrapped) ro_after_wrap++;
          if (exp_row == (1 << ROW_W) - 1) wrapped = 1;
          exp_row = next_row(exp_row);
          n_ro++;
        end
        if (n_rises > 0) check(high_run >= PRE, "R5 precharge", high_run, PRE);
        last_spacing = cyc - last_fall;
        last_fall = cyc;
        n_falls++;
        low_run = 1;
        cas_hold = cas_n ? 0 : 1;
        ro_cas_bad = 0;
      end else if (!ras_n) begin
        low_run++;
        if (!cas_n) cas_hold++;
        if (cur_ro && !cas_n) ro_cas_bad = 1;
      end else if (!prev_ras && ras_n) begin
        check(low_run == RASL, "R5 ras low width", low_run, RASL);
        if (!cur_ro) check(cas_hold == CHR, "R4 cas hold", cas_hold, CHR);
        else check(!ro_cas_bad, "R10 cas high in row cycle", ro_cas_bad, 0);
        n_rises++;
        high_run = 1;
        cas_pre = cas_n ? 0 : 1;
      end else begin
        high_run++;
        cas_pre = cas_n ? 0 : cas_pre + 1;
      end
      if (init_done && !prev_init) begin
        check(n_rises == WARM && n_falls == WARM, "R3 warm-up count at init_done", n_rises, WARM);
        check(n_ro == 0, "R3 warm-up cycles are CBR", n_ro, 0);
      end
      prev_init = init_done;
      prev_ras = ras_n;
      // grant driver
      if (!req) begin
        grant = 1'b0;
        wt = 0;
        if (rnd_mode && ($urandom % 6 == 0)) mode_tb = ~mode_tb;
      end else if (!grant && !blocked) begin
        if (wt >= gdelay) begin
          grant = 1'b1;
          if (rnd_delay) gdelay = $urandom % 4;
        end else wt++;
      end
    end
  end

  initial begin
    int f0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(!req && ras_n && cas_n, "R1 strobes/req in reset", {req, ras_n, cas_n}, 3'b011);
    check(!init_done && !ovf && row == '0, "R1 flags in reset", {init_done, ovf}, 0);
    rst_n = 1'b1;
    wait (init_done);
    @(negedge clk);
    check(!early_req, "R2 no request during pause", early_req, 0);
    check(first_req >= PAUSE && first_req <= PAUSE + 2, "R2 request after pause", first_req, PAUSE + 1);
    check(last_spacing == b2b_len(0), "R9 warm-up back-to-back", last_spacing, b2b_len(0));
    // steady rate with fixed latency
    gdelay = 2;
    f0 = n_falls;
    wait (n_falls == f0 + 2);
    for (int k = 0; k < 4; k++) begin
      f0 = n_falls;
      wait (n_falls == f0 + 1);
      check(last_spacing == IVAL, "R6 interval spacing", last_spacing, IVAL);
    end
    check(!ovf, "R8 no overflow when served", ovf, 0);
    // withhold grant for three intervals
    f0 = n_falls;
    wait (n_falls == f0 + 1);
    blocked = 1;
    repeat (3 * IVAL) @(negedge clk);
    check(req, "R7 request held without grant", req, 1);
    check(ovf, "R8 overflow after missed interval", ovf, 1);
    blocked = 0;
    f0 = n_falls;
    wait (n_falls == f0 + 2);
    check(last_spacing == b2b_len(0), "R9 missed refresh back-to-back", last_spacing, b2b_len(0));
    wait (n_falls == f0 + 3);
    check(last_spacing == b2b_len(0), "R9 missed refresh back-to-back", last_spacing, b2b_len(0));
    repeat (b2b_len(0) + PRE + 4) @(negedge clk);
    check(n_falls == f0 + 3, "R9 exactly the missed count", n_falls - f0, 3);
    check(!req, "R7 request released after burst", req, 0);
    // random latency and random mode
    rnd_delay = 1;
    rnd_mode = 1;
    f0 = n_falls;
    wait (n_falls == f0 + 40);
    rnd_mode = 0;
    @(negedge clk);
    wait (!req);
    mode_tb = 1'b1;
    wait (ro_after_wrap >= 3);
    check(wrapped, "R10 row wrap seen", wrapped, 1);
    check(init_done && ovf, "R3 R8 flags remain set", {init_done, ovf}, 3);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule